// File: doc/BRIEF.md
# Per-Core Interrupt Controller Register File

This block is the register file that sits behind the memory-mapped window of a per-core interrupt controller. A request carries a 12-bit byte offset, a byte count and write data. The block decodes the 8-byte slot that the offset falls in to one named 32-bit register. A write merges the new bytes into the register and then applies that register's own write policy: a kept-bits mask, forced-one bits, read-only fields or a side effect. A read returns the addressed bytes shifted down to bit 0. Each request gets a response exactly one cycle later, with read data and an error flag.

Two internal flags travel with the registers. The first is a software-enable flag, taken from bit 8 of the spurious-vector register. The second is an error-pending flag, which drives a two-step clear of the error-status register. Error bits found by the hardware enter that register through a separate input. Interrupt prioritisation, delivery, the timer countdown and inter-processor commands are handled elsewhere.

Top module: `intc_regfile`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_err` and `sw_enable` are 0, and every register reads zero, except destination format (offset 0xE0), which reads 0xFFFFFFFF. Every request produces `rsp_valid` one cycle later and no other cycle does. Write responses and error responses return `rsp_rdata` = 0.
- R2: The low 3 offset bits are ignored when a slot is selected. The mapped slots are 0x20, 0x30, 0x80, 0xD0, 0xE0, 0xF0, 0x100–0x278 (three read-only arrays, one entry every 8 bytes), 0x280, 0x320, 0x330, 0x340, 0x350, 0x360, 0x370, 0x380, 0x390 and 0x3E0. A request gets `rsp_err` = 1 in three cases: its slot is not mapped, its size is 0 or greater than 8, or `offset[2:0] + size > 8`. A request with `rsp_err` = 1 changes no state.
- R3: Byte lanes. For an access at byte b = `offset[2:0]` with n bytes, read byte k of `rsp_rdata` is byte b+k of the register, or zero when b+k > 3 or k ≥ n. A write replaces register bytes b to b+n-1 with the low bytes of `req_wdata`, dropping any byte above 3, before the register's write policy is applied.
- R4: The ID register (0x20) and task-priority register (0x80) keep only bits 7:0 of a write. The version register (0x30) always reads the parameter `VERSION`. The current-count register (0x390) and all array entries read zero. Writes to these read-only registers and entries are ignored.
- R5: The logical-destination register (0xD0) keeps only bits 31:24 of a write. The destination-format register (0xE0) has bits 27:0 forced to one by every write.
- R6: In each of the six vector-table entries (0x320–0x370), bits 12 and 14 are read-only and keep their reset value of 0. A write updates all the other bits.
- R7: The spurious-vector register (0xF0) stores all 32 bits of a write. Each successful write to it copies the new bit 8 into `sw_enable`, and no other request changes `sw_enable`.
- R8: A write to error status (0x280) while the pending flag is clear sets the flag and leaves the register unchanged. A write while the flag is set clears the register and clears the flag.
- R9: A successful read of error status returns its current value and clears the pending flag.
- R10: Each cycle, `err_in` is ORed into error status. This happens after any clear by a write in that same cycle.
- R11: The initial-count register (0x380) stores all 32 bits. The divide-configuration register (0x3E0) keeps only bits 3, 1 and 0 (mask 0xB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset into the register window |
| req_size | input | 4 | Byte count of the access (1 to 8) |
| req_wdata | input | 32 | Write data, aligned to bit 0 |
| err_in | input | ERR_W | Error bits to OR into error status |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Decode or size error for the request |
| rsp_rdata | output | 32 | Read data, aligned to bit 0 |
| sw_enable | output | 1 | Software-enable flag |

## Verification
A wrong pending flag cannot be seen at once. It shows up only at the next write to error status: the register is either cleared when it should hold, or kept when it should be cleared. The following read of that register then returns the wrong value. A wrongly stored mask or read-only bit becomes visible on the first read of that register, one cycle after the read is issued. A wrong decode or size check shows on `rsp_err` in the cycle right after the request. A reference model that is stepped in lockstep and compared on every response catches each of these faults at the first port cycle where it surfaces.

// File: rtl/intc_regfile.sv
module intc_regfile #(
  parameter logic [31:0] VERSION = 32'h0006_0014,
  parameter int          ERR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [11:0]      req_addr,
  input  logic [3:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic [ERR_W-1:0] err_in,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             sw_enable
);

  localparam int          NLVT    = 6;
  localparam logic [31:0] LVT_RO  = 32'h0000_5000;
  localparam logic [31:0] DFR_ONE = 32'h0FFF_FFFF;
  localparam logic [31:0] DCR_KEEP = 32'h0000_000B;

  typedef enum logic [3:0] {
    K_NONE, K_ID, K_VER, K_TPR, K_LDR, K_DFR, K_SVR, K_ARR,
    K_ESR, K_LVT, K_ICR, K_CCR, K_DCR
  } kind_t;

  logic [31:0] id_q, tpr_q, ldr_q, dfr_q, svr_q, esr_q, icr_q, dcr_q;
  logic [31:0] lvt_q [NLVT];
  logic        pend_q, swen_q;

  logic [11:0] base;
  logic [2:0]  lane;
  logic [5:0]  sh;
  logic [2:0]  lvt_idx;
  kind_t       kind;
  logic        bad_size, ok, wr, rd;
  logic [31:0] cur, keep_mask, wmask, merged, rdata, err_ext;
  logic        esr_clear;

  assign base    = {req_addr[11:3], 3'b000};
  assign lane    = req_addr[2:0];
  assign sh      = {lane, 3'b000};
  assign lvt_idx = base[6:4] - 3'd2;
  assign err_ext = 32'(err_in);

  assign bad_size = (req_size == 4'd0) || (req_size > 4'd8) ||
                    ({1'b0, lane} + req_size > 4'd8);

  always_comb begin
    kind = K_NONE;
    case (base)
      12'h020: kind = K_ID;
      12'h030: kind = K_VER;
      12'h080: kind = K_TPR;
      12'h0D0: kind = K_LDR;
      12'h0E0: kind = K_DFR;
      12'h0F0: kind = K_SVR;
      12'h280: kind = K_ESR;
      12'h380: kind = K_ICR;
      12'h390: kind = K_CCR;
      12'h3E0: kind = K_DCR;
      default: begin
        if (base >= 12'h100 && base <= 12'h278)
          kind = K_ARR;
        else if (base >= 12'h320 && base <= 12'h370 && base[3:0] == 4'h0)
          kind = K_LVT;
      end
    endcase
  end

  assign ok = req_valid && (kind != K_NONE) && !bad_size;
  assign wr = ok && req_write;
  assign rd = ok && !req_write;

  always_comb begin
    case (kind)
      K_ID:    cur = id_q;
      K_VER:   cur = VERSION;
      K_TPR:   cur = tpr_q;
      K_LDR:   cur = ldr_q;
      K_DFR:   cur = dfr_q;
      K_SVR:   cur = svr_q;
      K_ESR:   cur = esr_q;
      K_LVT:   cur = lvt_q[lvt_idx];
      K_ICR:   cur = icr_q;
      K_DCR:   cur = dcr_q;
      default: cur = 32'h0;
    endcase
  end

  assign keep_mask = (req_size >= 4'd4) ? 32'hFFFF_FFFF
                   : (32'd1 << {req_size[1:0], 3'b000}) - 32'd1;
  assign wmask  = keep_mask << sh;
  assign merged = (cur & ~wmask) | ((req_wdata << sh) & wmask);
  assign rdata  = (cur >> sh) & keep_mask;

  assign esr_clear = wr && (kind == K_ESR) && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q <= '0; tpr_q <= '0; ldr_q <= '0; dfr_q <= '1;
      svr_q <= '0; icr_q <= '0; dcr_q <= '0;
      swen_q <= 1'b0;
      for (int i = 0; i < NLVT; i++) lvt_q[i] <= '0;
    end else if (wr) begin
      case (kind)
        K_ID:  id_q  <= {24'h0, merged[7:0]};
        K_TPR: tpr_q <= {24'h0, merged[7:0]};
        K_LDR: ldr_q <= {merged[31:24], 24'h0};
        K_DFR: dfr_q <= merged | DFR_ONE;
        K_SVR: begin
          svr_q  <= merged;
          swen_q <= merged[8];
        end
        K_LVT: lvt_q[lvt_idx] <= (merged & ~LVT_RO) | (lvt_q[lvt_idx] & LVT_RO);
        K_ICR: icr_q <= merged;
        K_DCR: dcr_q <= merged & DCR_KEEP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      esr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      esr_q <= (esr_clear ? 32'h0 : esr_q) | err_ext;
      if (wr && kind == K_ESR)      pend_q <= !pend_q;
      else if (rd && kind == K_ESR) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !ok;
      rsp_rdata <= rd ? rdata : 32'h0;
    end
  end

  assign sw_enable = swen_q;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_ZERO_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 4'd0) |=> rsp_err); // R2
  AST_ESR_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind == K_ESR && !pend_q) |=> (pend_q && esr_q == ($past(esr_q) | $past(err_ext)))); // R8
  AST_ESR_SECOND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind == K_ESR && pend_q) |=> (!pend_q && esr_q == $past(err_ext))); // R8
  AST_ESR_READ_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && kind == K_ESR) |=> !pend_q); // R9
  AST_SWEN_ONLY_BY_SVR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && kind == K_SVR) |=> $stable(sw_enable)); // R7

endmodule

// File: tb/test_intc_regfile.sv
module test_intc_regfile;
  localparam logic [31:0] VER = 32'h0006_0014;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  err_in = '0;
  logic        rsp_valid, rsp_err, sw_enable;
  logic [31:0] rsp_rdata;

  intc_regfile #(.VERSION(VER), .ERR_W(8)) i_intc_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .err_in(err_in), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .sw_enable(sw_enable));

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  logic [31:0] m_id, m_tpr, m_ldr, m_dfr, m_svr, m_esr, m_icr, m_dcr;
  logic [31:0] m_lvt [6];
  bit m_pend, m_swen;
  bit e_valid, e_err;
  logic [31:0] e_rdata;

  task automatic model_reset();
    m_id = 0; m_tpr = 0; m_ldr = 0; m_dfr = 32'hFFFF_FFFF; m_svr = 0;
    m_esr = 0; m_icr = 0; m_dcr = 0; m_pend = 0; m_swen = 0;
    for (int i = 0; i < 6; i++) m_lvt[i] = 0;
  endtask

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit w, int addr, int size,
                      logic [31:0] data, logic [7:0] e);
    int base, b, li;
    bit mapped, bad, ok;
    logic [31:0] cur, mg;
    base = addr & ~7; b = addr & 7; mapped = 1; cur = 0; li = 0;
    if (base == 'h20) cur = m_id;
    else if (base == 'h30) cur = VER;
    else if (base == 'h80) cur = m_tpr;
    else if (base == 'hD0) cur = m_ldr;
    else if (base == 'hE0) cur = m_dfr;
    else if (base == 'hF0) cur = m_svr;
    else if (base == 'h280) cur = m_esr;
    else if (base == 'h380) cur = m_icr;
    else if (base == 'h390) cur = 0;
    else if (base == 'h3E0) cur = m_dcr;
    else if (base >= 'h100 && base <= 'h278) cur = 0;
    else if (base >= 'h320 && base <= 'h370 && (base % 16) == 0) begin
      li = (base - 'h320) / 16; cur = m_lvt[li];
    end else mapped = 0;
    bad = (size < 1) || (size > 8) || (b + size > 8);
    ok = v && mapped && !bad;
    e_valid = v; e_err = v && !ok; e_rdata = 0;
    if (ok && !w) begin
      for (int k = 0; k < 4; k++)
        if (k < size && b + k < 4) e_rdata[8*k +: 8] = cur[8*(b+k) +: 8];
      if (base == 'h280) m_pend = 0;
    end
    if (ok && w) begin
      mg = cur;
      for (int k = 0; k < 4; k++)
        if (k >= b && k < b + size) mg[8*k +: 8] = data[8*(k-b) +: 8];
      if (base == 'h20) m_id = mg & 32'hFF;
      else if (base == 'h80) m_tpr = mg & 32'hFF;
      else if (base == 'hD0) m_ldr = mg & 32'hFF00_0000;
      else if (base == 'hE0) m_dfr = mg | 32'h0FFF_FFFF;
      else if (base == 'hF0) begin m_svr = mg; m_swen = mg[8]; end
      else if (base == 'h380) m_icr = mg;
      else if (base == 'h3E0) m_dcr = mg & 32'hB;
      else if (base == 'h280) begin
        if (m_pend) begin m_esr = 0; m_pend = 0; end
        else m_pend = 1;
      end else if (base >= 'h320 && base <= 'h370 && (base % 16) == 0)
        m_lvt[li] = (mg & ~32'h5000) | (m_lvt[li] & 32'h5000);
    end
    m_esr = m_esr | {24'h0, e};
    req_valid = v; req_write = w; req_addr = 12'(addr);
    req_size = 4'(size); req_wdata = data; err_in = e;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; err_in = 0;
    check(tag, "rsp_valid", {31'h0, rsp_valid}, {31'h0, e_valid});
    check(tag, "rsp_err", {31'h0, rsp_err}, {31'h0, e_err});
    check(tag, "rsp_rdata", rsp_rdata, e_rdata);
    check(tag, "sw_enable", {31'h0, sw_enable}, {31'h0, m_swen});
  endtask

  task automatic rd(string tag, int a, int s = 4);
    step(tag, 1, 0, a, s, 0, 0);
  endtask
  task automatic wr(string tag, int a, logic [31:0] d, int s = 4);
    step(tag, 1, 1, a, s, d, 0);
  endtask
  task automatic idle(string tag, logic [7:0] e = 0);
    step(tag, 0, 0, 0, 0, 0, e);
  endtask

  initial begin
    int ai, sz;
    int bases[20] = '{'h20,'h30,'h80,'hD0,'hE0,'hF0,'h100,'h1A8,'h200,'h280,
                      'h320,'h340,'h370,'h380,'h390,'h3E0,'h90,'h300,'h28,'h3F0};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values and idle response
    idle("R1");
    rd("R1", 'hE0); rd("R1", 'h20); rd("R1", 'hF0); rd("R1", 'h350);
    // R4 masks and read-only registers
    rd("R4", 'h30);
    wr("R4", 'h20, 32'hAABBCCDD); rd("R4", 'h20);
    wr("R4", 'h80, 32'h1234_56F0); rd("R4", 'h80);
    wr("R4", 'h30, 32'hFFFF_FFFF); rd("R4", 'h30);
    wr("R4", 'h390, 32'hDEAD_BEEF); rd("R4", 'h390);
    wr("R4", 'h1A8, 32'hFFFF_FFFF); rd("R4", 'h1A8); rd("R4", 'h270);
    // R5 destination registers
    wr("R5", 'hD0, 32'h1234_5678); rd("R5", 'hD0);
    wr("R5", 'hE0, 32'h0); rd("R5", 'hE0);
    wr("R5", 'hE0, 32'h5000_0000); rd("R5", 'hE0);
    // R6 vector-table read-only bits
    wr("R6", 'h350, 32'hFFFF_FFFF); rd("R6", 'h350);
    wr("R6", 'h320, 32'h0001_50FF); rd("R6", 'h320); rd("R6", 'h370);
    // R7 software enable
    wr("R7", 'hF0, 32'h0000_01FF); rd("R7", 'hF0);
    wr("R7", 'hF0, 32'h0000_00FF);
    wr("R7", 'hF1, 32'h01, 1); rd("R7", 'hF0);
    rd("R7", 'hF0); idle("R7");
    // R10 error input
    idle("R10", 8'h05); rd("R10", 'h280);
    // R8 two-write clear
    wr("R8", 'h280, 0); rd("R8", 'h280);
    idle("R8", 8'h30);
    wr("R8", 'h280, 0); wr("R8", 'h280, 0); rd("R8", 'h280);
    // R9 read clears pending
    idle("R9", 8'h09); wr("R9", 'h280, 0); rd("R9", 'h280);
    wr("R9", 'h280, 0); rd("R9", 'h280);
    wr("R9", 'h280, 0); rd("R9", 'h280);
    // R10 clear and new error in the same cycle
    wr("R10", 'h280, 0); step("R10", 1, 1, 'h280, 4, 0, 8'h40); rd("R10", 'h280);
    // R11 counts and divide
    wr("R11", 'h380, 32'h8765_4321); rd("R11", 'h380);
    wr("R11", 'h3E0, 32'hFFFF_FFFF); rd("R11", 'h3E0);
    // R3 byte lanes
    wr("R3", 'h380, 32'h1122_3344);
    wr("R3", 'h382, 32'hAB, 1); rd("R3", 'h380);
    rd("R3", 'h381, 2); rd("R3", 'h384, 4); rd("R3", 'h383, 1);
    wr("R3", 'h383, 32'hCCDD_EEFF, 5); rd("R3", 'h380);
    // R2 decode and size errors
    rd("R2", 'h90); wr("R2", 'h300, 32'h1); rd("R2", 'h28);
    wr("R2", 'h386, 32'hFFFF_FFFF, 4); rd("R2", 'h380);
    rd("R2", 'h380, 0); rd("R2", 'h380, 9); rd("R2", 'h387, 1); rd("R2", 'h387, 2);
    wr("R2", 'h280, 0, 0); rd("R2", 'h280);
    // R3 mixed random traffic
    for (int n = 0; n < 400; n++) begin
      ai = bases[$urandom_range(0, 19)] + $urandom_range(0, 7);
      sz = $urandom_range(0, 9);
      step("R3", $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, ai, sz,
           $urandom(), ($urandom_range(0, 7) == 0) ? 8'($urandom()) : 8'h0);
    end
    // R1 reset again
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; model_reset();
    rd("R1", 'h280); rd("R1", 'hE0); idle("R1");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule